// File: doc/BRIEF.md
# Vector Configuration and Length Unit

This block executes the vector configuration step of a core whose vector registers are 128 bits wide. On a configuration request it takes a requested application vector length (either a full register operand or a small unsigned immediate, chosen by a select input) and a requested type word. The type word carries four fields: the element width code, the register group multiplier code, and the tail-agnostic and mask-agnostic flags. The block decides whether the element width and group multiplier pair is supported and derives the maximum vector length for that pair. It then grants a length and writes the granted length and the resulting type word into two architectural state registers.

Element widths of 8, 16 and 32 bits are supported. Fractional group multipliers are accepted only when the element width times the fraction's denominator does not exceed 32 bits. An unsupported pair sets the illegal flag in the stored type word, forces the length to zero, and still records the requested fields so that software can read back what it asked for. The illegal flag is also driven on a port of its own for the rest of the core.

Top module: `vcfg_unit`

## Requirements
- R1: After reset the stored type word is 0x8000_0000 (illegal flag set, every other bit 0), the stored length is 0 and the done pulse is low.
- R2: The stored type word places the multiplier code in bits 2:0, the width code in bits 5:3, the tail flag in bit 6, the mask flag in bit 7 and the illegal flag in bit 31; bits 30:8 always read 0, and bits 31:8 of the requested word are ignored.
- R3: Width codes 000 (8-bit), 001 (16-bit) and 010 (32-bit) are the only accepted ones; codes 011 to 111 make the request illegal.
- R4: Multiplier codes 100 (reserved) and 101 (one eighth) make the request illegal with any width.
- R5: Multiplier code 110 (one quarter) is accepted only with the 8-bit width, and code 111 (one half) is rejected with the 32-bit width.
- R6: For a legal pair the maximum length is 128 divided by the element width, times the multiplier (codes 000/001/010/011 mean 1/2/4/8, 111 means 1/2, 110 means 1/4): from 4 up to 128 for 8-bit, 4 up to 64 for 16-bit, 4 up to 32 for 32-bit.
- R7: A requested length above the maximum is granted as the maximum; a request at or below the maximum is granted unchanged.
- R8: An illegal request stores the illegal flag as 1, stores the requested mask, tail, width and multiplier fields unchanged, drives the illegal output high and stores a length of 0, whatever length was asked for.
- R9: The stored length and type word change on the clock edge that samples a request and at no other edge, and the done output is high for exactly the cycle after each request.
- R10: With the immediate select high the requested length is the 5-bit immediate zero-extended; with it low it is the full 32-bit register operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_valid | input | 1 | Configuration request in this cycle |
| avl_from_imm | input | 1 | 1: take the requested length from the immediate |
| avl_rs | input | 32 | Requested length from a register operand |
| avl_uimm | input | 5 | Requested length as an unsigned immediate |
| vtype_in | input | 32 | Requested type word |
| vl_out | output | 8 | Stored granted length |
| vtype_out | output | 32 | Stored type word |
| vill_out | output | 1 | Illegal flag of the stored type word |
| cfg_done | output | 1 | One-cycle pulse after a request |

## Verification
Length saturation and illegality detection act on the same request, and the case where both apply at once is the one that matters: an unsupported pair combined with a requested length far above any maximum. Such requests are sent back to back with legal saturating requests, so that each stored result must follow from its own request only. The scoreboard expects a length of zero with the requested fields preserved whenever the pair is illegal, regardless of how large the requested length was, and expects the saturated maximum on the next legal request.

// File: rtl/vcfg_pkg.sv
// Package: shared field layout for the vector configuration unit.
// Assumes the low byte of the type word holds the four requested fields.
package vcfg_pkg;

    localparam int unsigned FIELD_W = 3;
    localparam int unsigned FIELDS_BITS = 8;

    // Requested fields, most significant first: mask flag in bit 7,
    // tail flag in bit 6, width code 5:3, multiplier code 2:0.
    typedef struct packed {
        logic                 mask_agn;
        logic                 tail_agn;
        logic [FIELD_W-1:0]   width_code;
        logic [FIELD_W-1:0]   mult_code;
    } cfg_fields_t;

    localparam logic [FIELD_W-1:0] MULT_RESERVED = 3'b100;

endpackage

// File: rtl/vcfg_legal.sv
// Module: decides whether a width/multiplier pair is supported and
// derives the maximum vector length for it.
// Assumes: VLEN is a power of two, ELEN a power of two of at least 8.
// A fraction 1/2^k is accepted when width_code + k <= log2(ELEN/8).
module vcfg_legal #(
    parameter int unsigned VLEN = 128,
    parameter int unsigned ELEN = 32,
    parameter int unsigned VL_W = $clog2(VLEN + 1)
) (
    input  logic [2:0]      width_code,
    input  logic [2:0]      mult_code,
    output logic            legal,
    output logic [VL_W-1:0] vlmax
);
    import vcfg_pkg::*;

    localparam int unsigned WIDTH_CODE_MAX = $clog2(ELEN / 8);
    localparam logic [VL_W-1:0] BYTES_PER_REG = VL_W'(VLEN / 8);

    logic            width_ok;
    logic            mult_ok;
    logic [2:0]      frac_shift;
    logic [VL_W-1:0] per_reg;
    logic [VL_W-1:0] scaled;

    // Legality of the width code and of the multiplier code against it.
    always_comb begin
        width_ok   = (int'(width_code) <= int'(WIDTH_CODE_MAX));
        frac_shift = 3'd4 - {1'b0, mult_code[1:0]};
        if (!mult_code[2]) begin
            mult_ok = 1'b1;
        end else if (mult_code == MULT_RESERVED) begin
            mult_ok = 1'b0;
        end else begin
            mult_ok = (int'(width_code) + int'(frac_shift)) <= int'(WIDTH_CODE_MAX);
        end
        legal = width_ok && mult_ok;
    end

    // Elements per register, scaled up or down by the multiplier.
    always_comb begin
        per_reg = BYTES_PER_REG >> width_code;
        if (mult_code[2]) begin
            scaled = per_reg >> frac_shift;
        end else begin
            scaled = per_reg << mult_code[1:0];
        end
        vlmax = legal ? scaled : '0;
    end

endmodule

// File: rtl/vcfg_grant.sv
// Module: picks the requested length source and grants a length.
// Assumes vlmax is 0 whenever legal is low.
module vcfg_grant #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IMM_W = 5,
    parameter int unsigned VL_W  = 8
) (
    input  logic             avl_from_imm,
    input  logic [XLEN-1:0]  avl_rs,
    input  logic [IMM_W-1:0] avl_uimm,
    input  logic             legal,
    input  logic [VL_W-1:0]  vlmax,
    output logic [VL_W-1:0]  vl_next
);
    logic [XLEN-1:0] avl_req;
    logic            over_max;

    // Select the length source and saturate against the maximum.
    always_comb begin
        avl_req  = avl_from_imm ? XLEN'(avl_uimm) : avl_rs;
        over_max = avl_req > XLEN'(vlmax);
        if (!legal) begin
            vl_next = '0;
        end else if (over_max) begin
            vl_next = vlmax;
        end else begin
            vl_next = avl_req[VL_W-1:0];
        end
    end

endmodule

// File: rtl/vcfg_state.sv
// Module: architectural length and type registers plus the done pulse.
// Assumes load is a single-cycle strobe; reset is synchronous, active low.
module vcfg_state #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned VL_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [VL_W-1:0] vl_next,
    input  logic [XLEN-1:0] vtype_next,
    output logic [VL_W-1:0] vl_q,
    output logic [XLEN-1:0] vtype_q,
    output logic            done_q
);
    localparam logic [XLEN-1:0] VTYPE_RESET = {1'b1, {(XLEN-1){1'b0}}};

    // Capture the granted configuration and raise done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q    <= '0;
            vtype_q <= VTYPE_RESET;
            done_q  <= 1'b0;
        end else begin
            done_q <= load;
            if (load) begin
                vl_q    <= vl_next;
                vtype_q <= vtype_next;
            end
        end
    end

endmodule

// File: rtl/vcfg_unit.sv
// Module: vector configuration unit top. Decodes the requested type
// word, checks legality, grants a length and stores both.
// Assumes requests arrive as single-cycle strobes with stable operands.
module vcfg_unit #(
    parameter int unsigned VLEN  = 128,
    parameter int unsigned ELEN  = 32,
    parameter int unsigned XLEN  = 32,
    parameter int unsigned IMM_W = 5,
    localparam int unsigned VL_W = $clog2(VLEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic             avl_from_imm,
    input  logic [XLEN-1:0]  avl_rs,
    input  logic [IMM_W-1:0] avl_uimm,
    input  logic [XLEN-1:0]  vtype_in,
    output logic [VL_W-1:0]  vl_out,
    output logic [XLEN-1:0]  vtype_out,
    output logic             vill_out,
    output logic             cfg_done
);
    import vcfg_pkg::*;

    cfg_fields_t     req_fields;
    logic            legal;
    logic [VL_W-1:0] vlmax;
    logic [VL_W-1:0] vl_next;
    logic [XLEN-1:0] vtype_next;
    logic            unused_vtype_hi;

    // Pull the requested fields from the low byte; the rest is ignored.
    always_comb begin
        req_fields      = cfg_fields_t'(vtype_in[FIELDS_BITS-1:0]);
        unused_vtype_hi = ^vtype_in[XLEN-1:FIELDS_BITS];
    end

    vcfg_legal #(
        .VLEN (VLEN),
        .ELEN (ELEN),
        .VL_W (VL_W)
    ) u_legal (
        .width_code (req_fields.width_code),
        .mult_code  (req_fields.mult_code),
        .legal      (legal),
        .vlmax      (vlmax)
    );

    vcfg_grant #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W),
        .VL_W  (VL_W)
    ) u_grant (
        .avl_from_imm (avl_from_imm),
        .avl_rs       (avl_rs),
        .avl_uimm     (avl_uimm),
        .legal        (legal),
        .vlmax        (vlmax),
        .vl_next      (vl_next)
    );

    // Build the stored type word: illegal flag on top, fields at the bottom.
    always_comb begin
        vtype_next                    = '0;
        vtype_next[XLEN-1]            = ~legal;
        vtype_next[FIELDS_BITS-1:0]   = req_fields;
    end

    vcfg_state #(
        .XLEN (XLEN),
        .VL_W (VL_W)
    ) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_valid),
        .vl_next    (vl_next),
        .vtype_next (vtype_next),
        .vl_q       (vl_out),
        .vtype_q    (vtype_out),
        .done_q     (cfg_done)
    );

    // Expose the stored illegal flag.
    assign vill_out = vtype_out[XLEN-1];

endmodule

// File: rtl/vcfg_unit_chk.sv
// Module: property checker for vcfg_unit, attached with bind.
// Assumes the same reset and clock as the unit it watches.
module vcfg_unit_chk #(
    parameter int unsigned VLEN = 128,
    parameter int unsigned XLEN = 32,
    parameter int unsigned VL_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_valid,
    input logic [VL_W-1:0] vl_out,
    input logic [XLEN-1:0] vtype_out,
    input logic            vill_out,
    input logic            cfg_done
);
    // R9: a request is followed by done in the next cycle
    p_done_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> cfg_done);

    // R9: no done without a request in the previous cycle
    p_no_stray_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> !cfg_done);

    // R9: state holds across edges without a request
    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> ($stable(vl_out) && $stable(vtype_out)));

    // R8: an illegal configuration carries a zero length
    p_vill_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vill_out |-> (vl_out == '0));

    // R2: the gap between the fields and the illegal flag is always 0
    p_gap_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vtype_out[XLEN-2:8] == '0);

    // R6: the granted length never exceeds the largest maximum
    p_len_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(vl_out) <= int'(VLEN));

endmodule

bind vcfg_unit vcfg_unit_chk #(
    .VLEN (VLEN),
    .XLEN (XLEN),
    .VL_W (VL_W)
) u_vcfg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .vl_out    (vl_out),
    .vtype_out (vtype_out),
    .vill_out  (vill_out),
    .cfg_done  (cfg_done)
);

// File: tb/test_vcfg_unit.sv
`timescale 1ns/1ps
// Bench: scoreboard for vcfg_unit. A driver task queues expected results,
// a monitor compares them when done pulses.
module test_vcfg_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_valid;
    logic        avl_from_imm;
    logic [31:0] avl_rs;
    logic [4:0]  avl_uimm;
    logic [31:0] vtype_in;
    logic [7:0]  vl_out;
    logic [31:0] vtype_out;
    logic        vill_out;
    logic        cfg_done;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 0;

    logic [7:0]  exp_vl_q[$];
    logic [31:0] exp_vt_q[$];
    string       exp_tag_q[$];
    logic [7:0]  last_vl;
    logic [31:0] last_vt;

    always #2 clk = ~clk;

    vcfg_unit i_vcfg_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_valid    (cfg_valid),
        .avl_from_imm (avl_from_imm),
        .avl_rs       (avl_rs),
        .avl_uimm     (avl_uimm),
        .vtype_in     (vtype_in),
        .vl_out       (vl_out),
        .vtype_out    (vtype_out),
        .vill_out     (vill_out),
        .cfg_done     (cfg_done)
    );

    // Reference legality, written as an explicit table.
    function automatic bit ref_legal(input logic [2:0] w, input logic [2:0] m);
        if (w > 3'b010) return 0;
        if (m == 3'b100 || m == 3'b101) return 0;
        if (m == 3'b110 && w != 3'b000) return 0;
        if (m == 3'b111 && w == 3'b010) return 0;
        return 1;
    endfunction

    // Reference maximum length, written as an explicit table.
    function automatic int ref_vlmax(input logic [2:0] w, input logic [2:0] m);
        case ({w, m})
            6'b000_110: return 4;
            6'b000_111: return 8;
            6'b000_000: return 16;
            6'b000_001: return 32;
            6'b000_010: return 64;
            6'b000_011: return 128;
            6'b001_111: return 4;
            6'b001_000: return 8;
            6'b001_001: return 16;
            6'b001_010: return 32;
            6'b001_011: return 64;
            6'b010_000: return 4;
            6'b010_001: return 8;
            6'b010_010: return 16;
            6'b010_011: return 32;
            default:    return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
        end
    endtask

    // Driver: present one request for one cycle and queue its expectation.
    task automatic send(input logic [31:0] vt, input logic [31:0] rs,
                        input logic [4:0] ui, input logic sel, input string tag);
        logic [31:0] avl;
        logic [31:0] ev;
        logic [31:0] evt;
        bit          lg;
        int          mx;
        avl = sel ? {27'd0, ui} : rs;
        lg  = ref_legal(vt[5:3], vt[2:0]);
        mx  = ref_vlmax(vt[5:3], vt[2:0]);
        if (!lg)                 ev = 0;
        else if (avl > 32'(mx))  ev = 32'(mx);
        else                     ev = avl;
        evt = {~lg, 23'd0, vt[7:0]};
        cfg_valid    = 1'b1;
        vtype_in     = vt;
        avl_rs       = rs;
        avl_uimm     = ui;
        avl_from_imm = sel;
        exp_vl_q.push_back(ev[7:0]);
        exp_vt_q.push_back(evt);
        exp_tag_q.push_back(tag);
        last_vl = ev[7:0];
        last_vt = evt;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        cfg_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: on each done pulse pop the oldest expectation and compare.
    always @(negedge clk) begin
        if (rst_n && cfg_done) begin
            if (exp_vl_q.size() == 0) begin
                check(0, "R9", "done without request", 32'(cfg_done), 32'd0);
            end else begin
                logic [7:0]  ev;
                logic [31:0] evt;
                string       tg;
                ev  = exp_vl_q.pop_front();
                evt = exp_vt_q.pop_front();
                tg  = exp_tag_q.pop_front();
                check(vl_out == ev, tg, "length", 32'(vl_out), 32'(ev));
                check(vtype_out == evt, tg, "type word", vtype_out, evt);
                check(vill_out == evt[31], tg, "illegal output", 32'(vill_out), 32'(evt[31]));
            end
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        cfg_valid    = 1'b0;
        avl_from_imm = 1'b0;
        avl_rs       = '0;
        avl_uimm     = '0;
        vtype_in     = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(vtype_out == 32'h8000_0000, "R1", "type word", vtype_out, 32'h8000_0000);
        check(vl_out == 8'd0, "R1", "length", 32'(vl_out), 32'd0);
        check(cfg_done == 1'b0, "R1", "done", 32'(cfg_done), 32'd0);
        check(vill_out == 1'b1, "R1", "illegal output", 32'(vill_out), 32'd1);

        // R3 R4 R5 R6: every width/multiplier pair, back to back, large length
        for (int w = 0; w < 8; w++) begin
            for (int m = 0; m < 8; m++) begin
                logic [2:0] wc;
                logic [2:0] mc;
                string tg;
                wc = 3'(w);
                mc = 3'(m);
                if (w > 2)                        tg = "R3";
                else if (m == 4 || m == 5)        tg = "R4";
                else if (!ref_legal(wc, mc))      tg = "R5";
                else                              tg = "R6";
                send({24'd0, wc[0], mc[0], wc, mc}, 32'd1000, 5'd0, 1'b0, tg);
            end
        end
        idle(2);

        // R7: one above, at, and one below the maximum for each legal pair
        for (int w = 0; w < 3; w++) begin
            for (int m = 0; m < 8; m++) begin
                if (ref_legal(3'(w), 3'(m))) begin
                    int mx;
                    mx = ref_vlmax(3'(w), 3'(m));
                    send({26'd0, 3'(w), 3'(m)}, 32'(mx + 1), 5'd0, 1'b0, "R7");
                    send({26'd0, 3'(w), 3'(m)}, 32'(mx), 5'd0, 1'b0, "R7");
                    send({26'd0, 3'(w), 3'(m)}, 32'(mx - 1), 5'd0, 1'b0, "R7");
                end
            end
        end
        send(32'h0000_0008, 32'hFFFF_FFFF, 5'd0, 1'b0, "R7");
        idle(2);

        // R2: upper request bits ignored, both flags carried
        send(32'hA5A5_A5C8, 32'd3, 5'd0, 1'b0, "R2");
        send(32'hFFFF_FF41, 32'd40, 5'd0, 1'b0, "R2");
        idle(2);

        // R8: illegal pair together with a huge length, then a legal one
        send(32'h0000_00DD, 32'hFFFF_FFFF, 5'd31, 1'b0, "R8");
        send(32'h0000_0003, 32'hFFFF_FFFF, 5'd31, 1'b0, "R7");
        send(32'h0000_0094, 32'd2, 5'd0, 1'b0, "R8");
        idle(2);

        // R10: length source select
        send(32'h0000_0000, 32'd2, 5'd31, 1'b1, "R10");
        send(32'h0000_0001, 32'd2, 5'd31, 1'b1, "R10");
        send(32'h0000_0001, 32'd3, 5'd31, 1'b0, "R10");
        send(32'h0000_0001, 32'd20, 5'd0, 1'b1, "R10");
        send(32'h0000_0011, 32'h0000_0100, 5'd7, 1'b0, "R10");

        // R9: operands move without a request; state must hold, done low
        cfg_valid    = 1'b0;
        vtype_in     = 32'h0000_00FF;
        avl_rs       = 32'd1;
        avl_from_imm = 1'b0;
        repeat (4) @(negedge clk);
        check(vl_out == last_vl, "R9", "length held", 32'(vl_out), 32'(last_vl));
        check(vtype_out == last_vt, "R9", "type held", vtype_out, last_vt);
        check(cfg_done == 1'b0, "R9", "done low when idle", 32'(cfg_done), 32'd0);
        check(exp_vl_q.size() == 0, "R9", "every request answered",
              32'(exp_vl_q.size()), 32'd0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule